// File: doc/BRIEF.md
# Hit List Link Framer

This block turns the short list of hit addresses found in one bunch crossing into a pair of fixed-format words for a parallel link. Each crossing, the upstream logic presents up to six 11-bit hit addresses, a count of how many of them are valid, and the 12-bit bunch-crossing ID. At the rising edge of the 40 MHz crossing clock that ends the crossing, the framer captures this list. During the next crossing it sends two 40-bit words on an 80 MHz bus, so the link carries 80 bits every 25 ns.

The first word of a pair carries the upper half of the crossing ID and entries 0 to 2 of the list. The second word carries the lower half of the ID and entries 3 to 5. Hit slots beyond the valid count are sent as zeros. A pair is sent for every crossing, including crossings with no hits, so the receiver sees an unbroken sequence of IDs. A word-enable strobe marks the cycles that carry link data, and the first word of each pair always starts at a rising edge of the crossing clock.

Top module: `hitlist_link_framer`

## Requirements
- R1: While `rst_n` is low, `link_wen` is 0 and `link_word` is all zeros.
- R2: The first word of a pair has bit 39 = 0, bits 38:33 = ID bits 11:6, bits 32:22 = entry 0, bits 21:11 = entry 1 and bits 10:0 = entry 2. Entry i is `hit_list[11*i+10 : 11*i]`.
- R3: The second word of a pair has bit 39 = 0, bits 38:33 = ID bits 5:0, bits 32:22 = entry 3, bits 21:11 = entry 4 and bits 10:0 = entry 5.
- R4: A slot whose entry index is not below `hit_count` is sent as 11 zeros, whatever value is on its `hit_list` bits.
- R5: A `hit_count` of 7 is treated as 6, so all six entries are sent.
- R6: A crossing with `hit_count` = 0 still produces both words, carrying its ID halves and all-zero slots.
- R7: Inputs are captured at the rising edge of `clk_bc` that ends a crossing. The first word is driven during the first `clk_link` cycle after the next `clk_bc` rising edge, and the second word is driven during the `clk_link` cycle after that.
- R8: `link_wen` is 1 in both word cycles. Once it has gone high after reset, it stays high.
- R9: `link_word` is all zeros in every cycle in which `link_wen` is 0.
- R10: Crossings presented back to back each produce their own pair, in order, with no gap and no mixing of entries between crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bc | input | 1 | 40 MHz bunch-crossing clock; its rising edges are aligned with rising edges of `clk_link` |
| clk_link | input | 1 | 80 MHz link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_list | input | 66 | Six 11-bit hit addresses, entry i at bits 11*i+10 : 11*i |
| hit_count | input | 3 | Number of valid entries, starting at entry 0 |
| bc_id | input | 12 | Bunch-crossing ID of the presented list |
| link_word | output | 40 | Link data word |
| link_wen | output | 1 | Word-enable strobe |

## Verification
The hardest situation to reach from the ports is a crossing boundary in the middle of a pair. There, the second word of one crossing must still be built from the old list in the same `clk_link` edge at which the next crossing's list is taken over. A fault at that point only shows when successive crossings carry different IDs and entries and are presented with no gap between them. The stream scenario therefore changes the inputs three crossings in a row, each just after a `clk_bc` edge. It then checks each of the six resulting words at its own `clk_link` cycle. The other scenarios put non-zero values on slots beyond the count, so that a missing mask or a wrong clamp changes a visible word.

// File: rtl/hlf_pkg.sv
package hlf_pkg;
  parameter int HLF_HIT_W    = 11;
  parameter int HLF_NUM_HITS = 6;
  parameter int HLF_BCID_W   = 12;
  parameter int HLF_WORD_W   = 40;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HI   = 2'd1,
    SEQ_LO   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hlf_rst_sync.sv
module hlf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/hlf_capture.sv
// Crossing-clock domain: masks entries beyond the count and holds the list
// for one crossing; a toggle marks each new capture.
module hlf_capture #(
  parameter int NUM_HITS = 6,
  parameter int HIT_W    = 11,
  parameter int BCID_W   = 12,
  parameter int CNT_W    = 3,
  localparam int LIST_W  = NUM_HITS * HIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIST_W-1:0] list_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [BCID_W-1:0] id_in,
  output logic [LIST_W-1:0] list_q,
  output logic [BCID_W-1:0] id_q,
  output logic              tog_q
);
  logic [LIST_W-1:0] list_masked;

  for (genvar g = 0; g < NUM_HITS; g++) begin : g_mask
    always_comb begin
      if (count_in > CNT_W'(g)) list_masked[g*HIT_W +: HIT_W] = list_in[g*HIT_W +: HIT_W];
      else                      list_masked[g*HIT_W +: HIT_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_q <= '0;
      id_q   <= '0;
      tog_q  <= 1'b0;
    end else begin
      list_q <= list_masked;
      id_q   <= id_in;
      tog_q  <= ~tog_q;
    end
  end
endmodule

// File: rtl/hlf_word_pack.sv
// Builds one link word: zero pad on top, then the ID half, then the slots
// with the lowest list entry in the most significant slot.
module hlf_word_pack #(
  parameter int SLOTS   = 3,
  parameter int HIT_W   = 11,
  parameter int IDH_W   = 6,
  parameter int WORD_W  = 40,
  localparam int PAY_W  = IDH_W + SLOTS * HIT_W,
  localparam int PAD_W  = WORD_W - PAY_W
) (
  input  logic [SLOTS*HIT_W-1:0] slots_in,
  input  logic [IDH_W-1:0]       id_half,
  output logic [WORD_W-1:0]      word_out
);
  logic [SLOTS*HIT_W-1:0] slots_ordered;

  for (genvar s = 0; s < SLOTS; s++) begin : g_order
    assign slots_ordered[(SLOTS-1-s)*HIT_W +: HIT_W] = slots_in[s*HIT_W +: HIT_W];
  end

  if (PAD_W > 0) begin : g_pad
    assign word_out = {{PAD_W{1'b0}}, id_half, slots_ordered};
  end else begin : g_nopad
    assign word_out = {id_half, slots_ordered};
  end
endmodule

// File: rtl/hlf_sequencer.sv
// Link-clock domain: takes over each new list and sends its two words.
module hlf_sequencer #(
  parameter int NUM_HITS = 6,
  parameter int HIT_W    = 11,
  parameter int BCID_W   = 12,
  parameter int WORD_W   = 40,
  localparam int LIST_W  = NUM_HITS * HIT_W,
  localparam int SLOTS   = NUM_HITS / 2,
  localparam int HALF_W  = SLOTS * HIT_W,
  localparam int IDH_W   = BCID_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIST_W-1:0] list_in,
  input  logic [BCID_W-1:0] id_in,
  input  logic              tog_in,
  output logic [WORD_W-1:0] word_q,
  output logic              wen_q
);
  import hlf_pkg::*;

  seq_state_e        state_q, state_d;
  logic              seen_q;
  logic              new_xing;
  logic [LIST_W-1:0] shadow_list_q;
  logic [BCID_W-1:0] shadow_id_q;
  logic [WORD_W-1:0] words [2];
  logic [WORD_W-1:0] word_d;
  logic              wen_d;

  assign new_xing = (tog_in != seen_q);

  for (genvar w = 0; w < 2; w++) begin : g_word
    logic [IDH_W-1:0] id_half;
    if (w == 0) begin : g_hi
      assign id_half = shadow_id_q[BCID_W-1 -: IDH_W];
    end else begin : g_lo
      assign id_half = shadow_id_q[IDH_W-1:0];
    end
    hlf_word_pack #(
      .SLOTS  (SLOTS),
      .HIT_W  (HIT_W),
      .IDH_W  (IDH_W),
      .WORD_W (WORD_W)
    ) pack_i (
      .slots_in (shadow_list_q[w*HALF_W +: HALF_W]),
      .id_half  (id_half),
      .word_out (words[w])
    );
  end

  always_comb begin
    state_d = state_q;
    word_d  = '0;
    wen_d   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (new_xing) state_d = SEQ_HI;
      end
      SEQ_HI: begin
        word_d  = words[0];
        wen_d   = 1'b1;
        state_d = SEQ_LO;
      end
      SEQ_LO: begin
        word_d  = words[1];
        wen_d   = 1'b1;
        state_d = new_xing ? SEQ_HI : SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      seen_q  <= 1'b0;
      word_q  <= '0;
      wen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= tog_in;
      word_q  <= word_d;
      wen_q   <= wen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_list_q <= '0;
      shadow_id_q   <= '0;
    end else if (new_xing) begin
      shadow_list_q <= list_in;
      shadow_id_q   <= id_in;
    end
  end
endmodule

// File: rtl/hitlist_link_framer.sv
module hitlist_link_framer #(
  parameter int NUM_HITS = hlf_pkg::HLF_NUM_HITS,
  parameter int HIT_W    = hlf_pkg::HLF_HIT_W,
  parameter int BCID_W   = hlf_pkg::HLF_BCID_W,
  parameter int WORD_W   = hlf_pkg::HLF_WORD_W,
  localparam int LIST_W  = NUM_HITS * HIT_W,
  localparam int CNT_W   = $clog2(NUM_HITS + 1)
) (
  input  logic              clk_bc,
  input  logic              clk_link,
  input  logic              rst_n,
  input  logic [LIST_W-1:0] hit_list,
  input  logic [CNT_W-1:0]  hit_count,
  input  logic [BCID_W-1:0] bc_id,
  output logic [WORD_W-1:0] link_word,
  output logic              link_wen
);
  logic              rst_bc_n;
  logic              rst_link_n;
  logic [LIST_W-1:0] cap_list;
  logic [BCID_W-1:0] cap_id;
  logic              cap_tog;

  hlf_rst_sync rst_bc_i   (.clk(clk_bc),   .rst_n_in(rst_n), .rst_n_out(rst_bc_n));
  hlf_rst_sync rst_link_i (.clk(clk_link), .rst_n_in(rst_n), .rst_n_out(rst_link_n));

  hlf_capture #(
    .NUM_HITS (NUM_HITS),
    .HIT_W    (HIT_W),
    .BCID_W   (BCID_W),
    .CNT_W    (CNT_W)
  ) capture_i (
    .clk      (clk_bc),
    .rst_n    (rst_bc_n),
    .list_in  (hit_list),
    .count_in (hit_count),
    .id_in    (bc_id),
    .list_q   (cap_list),
    .id_q     (cap_id),
    .tog_q    (cap_tog)
  );

  hlf_sequencer #(
    .NUM_HITS (NUM_HITS),
    .HIT_W    (HIT_W),
    .BCID_W   (BCID_W),
    .WORD_W   (WORD_W)
  ) seq_i (
    .clk     (clk_link),
    .rst_n   (rst_link_n),
    .list_in (cap_list),
    .id_in   (cap_id),
    .tog_in  (cap_tog),
    .word_q  (link_word),
    .wen_q   (link_wen)
  );
endmodule

// File: rtl/hitlist_link_framer_chk.sv
module hitlist_link_framer_chk #(
  parameter int WORD_W = 40
) (
  input logic              clk_link,
  input logic              rst_n,
  input logic [WORD_W-1:0] link_word,
  input logic              link_wen
);
  // R2, R3: reserved top bit is never set in a sent word
  assert_reserved_zero_R2: assert property (@(posedge clk_link) disable iff (!rst_n)
    link_wen |-> (link_word[WORD_W-1] == 1'b0));

  // R9: idle output is quiet
  assert_idle_quiet_R9: assert property (@(posedge clk_link) disable iff (!rst_n)
    !link_wen |-> (link_word == '0));

  // R8: a word pair always spans two cycles
  assert_pair_len_R8: assert property (@(posedge clk_link) disable iff (!rst_n)
    $rose(link_wen) |=> link_wen);

  // R8: once running, the strobe never drops
  assert_continuous_R8: assert property (@(posedge clk_link) disable iff (!rst_n)
    $past(link_wen) |-> link_wen);
endmodule

bind hitlist_link_framer hitlist_link_framer_chk #(.WORD_W(WORD_W)) chk_i (
  .clk_link  (clk_link),
  .rst_n     (rst_n),
  .link_word (link_word),
  .link_wen  (link_wen)
);

// File: tb/hitlist_link_framer_tb_top.sv
`timescale 1ns/1ps
module hitlist_link_framer_tb_top;
  logic        clk_bc;
  logic        clk_link;
  logic        rst_n;
  logic [65:0] hit_list;
  logic [2:0]  hit_count;
  logic [11:0] bc_id;
  logic [39:0] link_word;
  logic        link_wen;

  int checks;
  int errors;

  hitlist_link_framer dut_i (
    .clk_bc    (clk_bc),
    .clk_link  (clk_link),
    .rst_n     (rst_n),
    .hit_list  (hit_list),
    .hit_count (hit_count),
    .bc_id     (bc_id),
    .link_word (link_word),
    .link_wen  (link_wen)
  );

  // 100 MHz link clock; crossing clock at half rate, rising edges aligned
  initial begin
    clk_link = 1'b0;
    forever #5 clk_link = ~clk_link;
  end
  initial begin
    clk_bc = 1'b0;
    #5;
    forever begin
      clk_bc = ~clk_bc;
      #10;
    end
  end

  function automatic logic [39:0] exp_word(input logic [65:0] lst, input int cnt,
                                           input logic [11:0] id, input int half);
    logic [39:0] w;
    int eff;
    eff = (cnt > 6) ? 6 : cnt;
    w = '0;
    w[38:33] = (half == 0) ? id[11:6] : id[5:0];
    for (int s = 0; s < 3; s++) begin
      int idx;
      idx = half * 3 + s;
      if (idx < eff) w[32 - 11*s -: 11] = lst[11*idx +: 11];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [65:0] lst, input int cnt, input logic [11:0] id);
    hit_list  = lst;
    hit_count = cnt[2:0];
    bc_id     = id;
  endtask

  // drive just after a crossing edge, capture at the next one, check both words
  task automatic one_crossing(input string req, input logic [65:0] lst, input int cnt,
                              input logic [11:0] id);
    @(posedge clk_bc);
    #3;
    drive(lst, cnt, id);
    @(posedge clk_bc);
    #25;
    chk({req, " R7 R2 first word"}, link_word, exp_word(lst, cnt, id, 0));
    chk_bit({req, " R8 wen first"}, link_wen, 1'b1);
    #10;
    chk({req, " R7 R3 second word"}, link_word, exp_word(lst, cnt, id, 1));
    chk_bit({req, " R8 wen second"}, link_wen, 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive({6{11'h7FF}}, 6, 12'hFFF);
    repeat (4) @(posedge clk_link);
    #2;
    chk("R1 reset word", link_word, 40'h0);
    chk_bit("R1 reset wen", link_wen, 1'b0);
    @(posedge clk_bc);
    #3;
    rst_n = 1'b1;
    @(posedge clk_link);
    #2;
    chk_bit("R9 idle wen after release", link_wen, 1'b0);
    chk("R9 idle word after release", link_word, 40'h0);
  endtask

  task automatic t_full;
    one_crossing("R2 R3 full", {11'h555, 11'h2AA, 11'h123, 11'h456, 11'h001, 11'h7FF}, 6, 12'hA5C);
  endtask

  task automatic t_partial;
    one_crossing("R4 partial", {11'h7F0, 11'h3C3, 11'h0F0, 11'h111, 11'h222, 11'h333}, 4, 12'h3E1);
    one_crossing("R4 single", {11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 11'h00C}, 1, 12'h801);
  endtask

  task automatic t_overcount;
    one_crossing("R5 count7", {11'h6AB, 11'h1CD, 11'h2EF, 11'h321, 11'h654, 11'h0A9}, 7, 12'h0FF);
  endtask

  task automatic t_empty;
    one_crossing("R6 empty", {6{11'h7FF}}, 0, 12'hFC0);
  endtask

  task automatic t_stream;
    logic [65:0] la, lb, lc;
    logic [11:0] ia, ib, ic;
    la = {11'h101, 11'h202, 11'h303, 11'h404, 11'h505, 11'h606};  ia = 12'h111;
    lb = {11'h7A1, 11'h7B2, 11'h7C3, 11'h7D4, 11'h7E5, 11'h7F6};  ib = 12'hEEE;
    lc = {11'h0AA, 11'h0BB, 11'h0CC, 11'h0DD, 11'h0EE, 11'h0FF};  ic = 12'h5A5;
    @(posedge clk_bc);
    #3 drive(la, 6, ia);
    @(posedge clk_bc);
    #3 drive(lb, 5, ib);
    @(posedge clk_bc);
    #3 drive(lc, 2, ic);
    #2;
    chk("R10 stream A first", link_word, exp_word(la, 6, ia, 0));
    #10;
    chk("R10 stream A second", link_word, exp_word(la, 6, ia, 1));
    @(posedge clk_bc);
    #5;
    chk("R10 stream B first", link_word, exp_word(lb, 5, ib, 0));
    #10;
    chk("R10 stream B second", link_word, exp_word(lb, 5, ib, 1));
    chk_bit("R8 wen continuous", link_wen, 1'b1);
    @(posedge clk_bc);
    #5;
    chk("R10 stream C first", link_word, exp_word(lc, 2, ic, 0));
    #10;
    chk("R10 stream C second", link_word, exp_word(lc, 2, ic, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk_link);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    repeat (8) @(posedge clk_bc);
    t_full();
    t_partial();
    t_overcount();
    t_empty();
    t_stream();
    t_full();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule